// File: doc/BRIEF.md
# Address Range Attribute Mapper

This block is a command engine that attaches an 8-bit attribute ID to a physical address range, or removes it. Memory is tagged at 512-byte chunk granularity. The per-chunk IDs are kept in a flat table in memory that holds one byte per chunk. The byte for chunk `c` sits at byte `c` above the table base. Eight chunk bytes share one 64-bit table word. One table word therefore covers exactly one 4 KiB page.

A command gives a start address, a byte length, a map/unmap select and an ID. The engine works out which chunks the range touches, including chunks it covers only partly. It then visits each table word that holds one of those chunks, in ascending order. For each word it reads the word, replaces only the bytes of the affected chunks, and writes the word back. After each write it pulses a page-invalidate output so that a lookaside buffer outside this block can drop its stale copy of that page. When the walk ends, a one-cycle done pulse is raised.

The walk is a five-state machine:
- `ST_IDLE` accepts a command. It goes to `ST_RD`, or to `ST_ZERO` when the length is zero.
- `ST_RD` holds a table read until memory is ready, then goes to `ST_WR`.
- `ST_WR` holds the merged write until memory is ready, then goes to `ST_NOTE`.
- `ST_NOTE` issues the page invalidate. It returns to `ST_IDLE` after the last word, or to `ST_RD` for the next word.
- `ST_ZERO` pulses done for a zero-length command and returns to `ST_IDLE`.

Top module: `attr_range_mapper`

## Requirements
- R1: A map command writes `cmd_id` into the table byte of every 512-byte chunk that overlaps the range, including chunks that are only partly covered.
- R2: An unmap command writes 0, the "no attribute" code, into the table byte of every overlapped chunk. `cmd_id` is ignored.
- R3: Table layout: the byte for chunk `c` is in the word at `mem_addr = TABLE_BASE + c/8`, bits `[8*(c%8)+7 : 8*(c%8)]`. Bytes of chunks outside the range, including those in the same word as chunks inside it, keep their old values.
- R4: For each touched table word, in ascending order, the engine makes exactly one read and then exactly one write to the same word address.
- R5: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ready` is high at a clock edge.
- R6: In the cycle after each write is accepted, `inv_valid` is high for one cycle. `inv_page` then carries that word's page number, which is the address divided by 4096.
- R7: `done` is high for exactly one cycle per command. For a non-zero length, `done` is high in the cycle after the last write is accepted, together with the final invalidate.
- R8: A zero-length command raises `done` in the cycle after it is accepted, with no memory access and no invalidate.
- R9: After reset the engine is idle. `busy` is high from the cycle after a command is accepted until the engine returns to idle. A command presented while `busy` is high is ignored. When idle, the engine makes no memory request.
- R10: A range that runs past the top of the address space is clamped at the last chunk.
- R11: A map overwrites any earlier ID on the chunks it covers, so the most recent command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command presented; taken when not busy |
| cmd_unmap | input | 1 | 1 = unmap (write 0), 0 = map |
| cmd_addr | input | ADDR_W | Start byte address of the range |
| cmd_len | input | ADDR_W | Length of the range in bytes |
| cmd_id | input | ID_W | Attribute ID for a map command |
| busy | output | 1 | Engine is walking a command |
| done | output | 1 | One-cycle completion pulse |
| inv_valid | output | 1 | Page invalidate pulse |
| inv_page | output | ADDR_W-12 | Page number to invalidate |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Table word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid while ready is high for a read |
| mem_ready | input | 1 | Memory accepts the request at this edge |

## Verification
The walk is swept over start addresses spread across a 64 KiB space. Each start is combined with offsets at a chunk start, inside a chunk, and on a chunk's last byte. Each is also combined with lengths of one byte, just under one chunk, one chunk, a chunk and a bit, one page, a page and a bit, and many pages. Together these separate the cases of a single partial byte, both word edges, and crossing or not crossing a word boundary. The sweep alternates map with unmap and a ready-always memory with a stalling one, so that handshake holding and the read-before-write order are exercised. Dedicated cases cover zero length, clamping at the top of the address space, overwriting a prior ID, and a command offered while busy.

// File: rtl/arm_pkg.sv
package arm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_NOTE,
        ST_ZERO
    } walk_state_t;
endpackage

// File: rtl/arm_span_calc.sv
module arm_span_calc #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_SHIFT = 9,
    localparam int CHW        = ADDR_W - CHUNK_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] len,
    output logic [CHW-1:0]    first_c,
    output logic [CHW-1:0]    last_c,
    output logic              empty
);
    logic [ADDR_W:0] end_x;

    always_comb begin
        end_x   = {1'b0, addr} + {1'b0, len} - {{ADDR_W{1'b0}}, 1'b1};
        empty   = (len == '0);
        first_c = addr[ADDR_W-1:CHUNK_SHIFT];
        // Clamp a range that runs past the top of the address space.
        if (end_x[ADDR_W]) begin
            last_c = '1;
        end else begin
            last_c = end_x[ADDR_W-1:CHUNK_SHIFT];
        end
    end
endmodule

// File: rtl/arm_lane_merge.sv
module arm_lane_merge #(
    parameter int ID_W   = 8,
    parameter int WORD_W = 64,
    parameter int CHW    = 23,
    localparam int LANES = WORD_W / ID_W,
    localparam int LB    = $clog2(LANES),
    localparam int WW    = CHW - LB
) (
    input  logic [WW-1:0]     word_idx,
    input  logic [CHW-1:0]    first_c,
    input  logic [CHW-1:0]    last_c,
    input  logic [ID_W-1:0]   id,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] new_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LB-1:0] LANE = LB'(g);
        logic [CHW-1:0] chunk;
        logic           hit;
        assign chunk = {word_idx, LANE};
        assign hit   = (chunk >= first_c) && (chunk <= last_c);
        assign new_word[g*ID_W +: ID_W] = hit ? id : old_word[g*ID_W +: ID_W];
    end
endmodule

// File: rtl/attr_range_mapper.sv
module attr_range_mapper
    import arm_pkg::*;
#(
    parameter int ADDR_W                 = 32,
    parameter int ID_W                   = 8,
    parameter int WORD_W                 = 64,
    parameter int CHUNK_SHIFT            = 9,
    parameter int MEM_AW                 = 32,
    parameter logic [MEM_AW-1:0] TABLE_BASE = 'h0010_0000,
    localparam int LANES                 = WORD_W / ID_W,
    localparam int LB                    = $clog2(LANES),
    localparam int CHW                   = ADDR_W - CHUNK_SHIFT,
    localparam int WW                    = CHW - LB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_unmap,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cmd_len,
    input  logic [ID_W-1:0]   cmd_id,
    output logic              busy,
    output logic              done,
    output logic              inv_valid,
    output logic [WW-1:0]     inv_page,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    walk_state_t       state, state_nx;
    logic [CHW-1:0]    first_r, last_r;
    logic [WW-1:0]     cur_w, last_w;
    logic [ID_W-1:0]   id_r;
    logic [WORD_W-1:0] wbuf;

    logic [CHW-1:0]    span_first, span_last;
    logic              span_empty;
    logic [WORD_W-1:0] merged;
    logic              at_last;

    arm_span_calc #(
        .ADDR_W      (ADDR_W),
        .CHUNK_SHIFT (CHUNK_SHIFT)
    ) u_span (
        .addr    (cmd_addr),
        .len     (cmd_len),
        .first_c (span_first),
        .last_c  (span_last),
        .empty   (span_empty)
    );

    arm_lane_merge #(
        .ID_W   (ID_W),
        .WORD_W (WORD_W),
        .CHW    (CHW)
    ) u_merge (
        .word_idx (cur_w),
        .first_c  (first_r),
        .last_c   (last_r),
        .id       (id_r),
        .old_word (mem_rdata),
        .new_word (merged)
    );

    assign at_last = (cur_w == last_w);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) state_nx = span_empty ? ST_ZERO : ST_RD;
            ST_RD:   if (mem_ready) state_nx = ST_WR;
            ST_WR:   if (mem_ready) state_nx = ST_NOTE;
            ST_NOTE: state_nx = at_last ? ST_IDLE : ST_RD;
            ST_ZERO: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_r <= '0;
            last_r  <= '0;
            cur_w   <= '0;
            last_w  <= '0;
            id_r    <= '0;
            wbuf    <= '0;
        end else begin
            if (state == ST_IDLE && cmd_valid) begin
                first_r <= span_first;
                last_r  <= span_last;
                cur_w   <= span_first[CHW-1:LB];
                last_w  <= span_last[CHW-1:LB];
                id_r    <= cmd_unmap ? '0 : cmd_id;
            end
            if (state == ST_RD && mem_ready) begin
                wbuf <= merged;
            end
            if (state == ST_NOTE && !at_last) begin
                cur_w <= cur_w + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = TABLE_BASE + MEM_AW'(cur_w);
        mem_wdata = wbuf;
        inv_valid = (state == ST_NOTE);
        inv_page  = cur_w;
        done      = (state == ST_ZERO) || (state == ST_NOTE && at_last);
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> mem_req && mem_we && $stable(mem_addr));

    // R6
    inv_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(mem_req && mem_we && mem_ready));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_len == '0 |=> done && !mem_req && !inv_valid);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !inv_valid);
endmodule

// File: tb/test_attr_range_mapper.sv
`timescale 1ns/1ps
module test_attr_range_mapper;
    localparam int AW  = 16;
    localparam int MAW = 16;
    localparam logic [15:0] BASE = 16'h0040;
    localparam int NCH = 128;
    localparam int NWD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_unmap = 1'b0;
    logic [15:0] cmd_addr = '0, cmd_len = '0;
    logic [7:0]  cmd_id = '0;
    logic        busy, done, inv_valid, mem_req, mem_we;
    logic [3:0]  inv_page;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    attr_range_mapper #(
        .ADDR_W(AW), .ID_W(8), .WORD_W(64), .CHUNK_SHIFT(9),
        .MEM_AW(MAW), .TABLE_BASE(BASE)
    ) i_attr_range_mapper (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_unmap(cmd_unmap),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_id(cmd_id),
        .busy(busy), .done(done), .inv_valid(inv_valid), .inv_page(inv_page),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Memory model with optional stalls
    logic [63:0] mem [NWD];
    logic [7:0]  ref_b [NCH];
    logic [7:0]  lfsr = 8'h5A;
    bit          stall_en = 0;
    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= stall_en ? lfsr[0] : 1'b1;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[3:0]] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr[3:0]];

    // Monitor
    int rd_cnt, wr_cnt, inv_cnt, done_cnt, ord_err, pg_err, done_inv_err, hold_err;
    int nxt_rd, nxt_wr, nxt_inv, last_pg, exp_words;
    bit done_seen, pend;
    logic [15:0] pend_addr;
    logic        pend_we;
    always @(posedge clk) begin
        if (rst_n) begin
            if (pend && !(mem_req && mem_addr == pend_addr && mem_we == pend_we)) hold_err++;
            pend = mem_req && !mem_ready;
            pend_addr = mem_addr;
            pend_we = mem_we;
            if (mem_req && mem_ready) begin
                if (!mem_we) begin
                    rd_cnt++;
                    if (int'(mem_addr) != int'(BASE) + nxt_rd) ord_err++;
                    nxt_rd++;
                end else begin
                    wr_cnt++;
                    if (int'(mem_addr) != int'(BASE) + nxt_wr || wr_cnt > rd_cnt) ord_err++;
                    nxt_wr++;
                end
            end
            if (inv_valid) begin
                inv_cnt++;
                if (int'(inv_page) != nxt_inv) pg_err++;
                nxt_inv++;
            end
            if (done) begin
                done_cnt++;
                done_seen = 1;
                if (exp_words > 0 && !(inv_valid && int'(inv_page) == last_pg)) done_inv_err++;
            end
        end
    end

    task automatic run_cmd(input bit unmap, input int addr, input int len, input int id,
                           input string rq, input bit interfere);
        int first, last, endx, fw, in_err, out_err;
        bit hit;
        first = addr >> 9;
        endx  = addr + len - 1;
        last  = (endx > 65535) ? 127 : (endx >> 9);
        fw    = first >> 3;
        exp_words = (len == 0) ? 0 : ((last >> 3) - fw + 1);
        last_pg   = last >> 3;
        if (len != 0)
            for (int c = first; c <= last; c++) ref_b[c] = unmap ? 8'h00 : 8'(id);
        rd_cnt = 0; wr_cnt = 0; inv_cnt = 0; done_cnt = 0; ord_err = 0; pg_err = 0;
        done_inv_err = 0; hold_err = 0;
        nxt_rd = fw; nxt_wr = fw; nxt_inv = fw; done_seen = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_unmap = unmap; cmd_addr = 16'(addr); cmd_len = 16'(len); cmd_id = 8'(id);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (k == 0) begin
                cmd_valid = 0;
                if (len != 0) check(busy == 1'b1, "R9 busy after accept", busy, 1);
            end
            if (interfere && k == 3) begin
                cmd_valid = 1; cmd_unmap = 0; cmd_addr = 16'hC000; cmd_len = 16'd512; cmd_id = 8'h77;
            end
            if (k == 4) cmd_valid = 0;
            if (done_seen) break;
        end
        cmd_valid = 0;
        if (!done_seen) check(0, "watchdog: command never completed", 0, 1);
        repeat (4) @(negedge clk);
        in_err = 0; out_err = 0;
        for (int c = 0; c < NCH; c++) begin
            hit = (len != 0) && c >= first && c <= last;
            if (mem[c >> 3][8*(c%8) +: 8] != ref_b[c]) begin
                if (hit) in_err++; else out_err++;
            end
        end
        check(in_err == 0, rq, in_err, 0);
        check(out_err == 0, "R3 bytes outside range kept", out_err, 0);
        if (len == 0) begin
            check(rd_cnt == 0 && wr_cnt == 0 && inv_cnt == 0 && done_cnt == 1,
                  "R8 zero length", rd_cnt + wr_cnt + inv_cnt, 0);
        end else begin
            check(rd_cnt == exp_words && wr_cnt == exp_words && ord_err == 0,
                  "R4 one read one write per word in order", rd_cnt, exp_words);
            check(inv_cnt == exp_words && pg_err == 0, "R6 page invalidates", inv_cnt, exp_words);
            check(done_cnt == 1 && done_inv_err == 0, "R7 single done with last invalidate", done_cnt, 1);
        end
        if (stall_en) check(hold_err == 0, "R5 request held while not ready", hold_err, 0);
        if (interfere) check(done_cnt == 1 && rd_cnt == exp_words, "R9 command while busy ignored", rd_cnt, exp_words);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    int lens [7] = '{1, 511, 512, 600, 4096, 5000, 20000};
    int offs [3] = '{0, 100, 511};

    initial begin
        int n, addr, id;
        bit um;
        for (int c = 0; c < NCH; c++) begin
            ref_b[c] = 8'hA0 ^ 8'(c);
            mem[c >> 3][8*(c%8) +: 8] = 8'hA0 ^ 8'(c);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && done == 0 && inv_valid == 0 && mem_req == 0,
              "R9 idle after reset", {busy, done, inv_valid, mem_req}, 0);

        n = 0;
        for (int s = 0; s < 128; s += 9)
            for (int o = 0; o < 3; o++)
                for (int l = 0; l < 7; l++) begin
                    addr = (s * 512 + offs[o]) & 16'hFFFF;
                    stall_en = n[0];
                    id = ((n * 29) + 1) & 255;
                    if (id == 0) id = 1;
                    um = (n % 4 == 3);
                    run_cmd(um, addr, lens[l], id, um ? "R2 unmap writes 0" : "R1 map writes id", 0);
                    n++;
                end

        stall_en = 0;
        run_cmd(0, 16'h1234, 0, 9, "R8 zero length leaves table", 0);
        run_cmd(0, 16'hFE10, 16'h3000, 8'h3C, "R10 clamp at top", 0);
        run_cmd(0, 0, 4096, 5, "R1 map page", 0);
        run_cmd(0, 1024, 1024, 9, "R11 later map overwrites", 0);
        stall_en = 1;
        run_cmd(1, 700, 3000, 8'hEE, "R2 unmap with stalls", 0);
        stall_en = 0;
        run_cmd(0, 0, 32768, 8'h21, "R1 long map", 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule